// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the control path that runs between the moment a CPU core accepts an interrupt and the first fetch of the handler. An interrupt controller presents one request with a priority level and a flag that marks the fast (shadow-register) interrupt. The core reports when its current instruction finishes and whether that instruction is a long-running string or multiply-accumulate operation that may be cut short. The sequencer decides when to take the request and tells the core when its instruction is being abandoned. It then runs a fixed list of steps, one per clock. Those steps read the interrupt number, clear the source's request bit, save and update the flag register, save the flags and the return PC, raise the interrupt priority level and load the handler address.

The block holds no architectural registers of its own. It reads the core's current flag word, PC, interrupt stack pointer, vector table base and fast vector register. It writes back through one write strobe and one data bus per register: flags, stack pointer, flag shadow, PC shadow, priority level and PC. Memory is a zero-wait bus whose read data is valid in the same cycle as the read strobe.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy, abandon, bus_rd, bus_wr, ack_clr and every register write strobe are low.
- R2: When idle, a pending request with insn_done high is accepted at that clock edge, and busy is high from the next cycle. A request with neither insn_done nor insn_abortable high is never accepted.
- R3: When idle, a pending request with insn_abortable high and insn_done low is accepted at once, and abandon is high in that same cycle.
- R4: The first busy cycle reads the interrupt number from address 0x000000, or from 0x000002 for a fast request, taking bits [7:0] of bus_rdata. The next cycle pulses ack_clr with ack_num equal to that number.
- R5: The flag word seen in the first busy cycle is kept in a temporary register. The second busy cycle writes it back with bit 7 (stack select), bit 6 (interrupt enable) and bit 4 (single-step) cleared and all other bits unchanged.
- R6: For a normal request, the third busy cycle writes the saved flags to address ISP-2 and sets ISP to ISP-2. The fourth writes the return PC to ISP-6 and sets ISP to ISP-6.
- R7: For a fast request, the saved flags go to the flag shadow and the return PC goes to the PC shadow, in the third and fourth busy cycles. There are no bus writes and no ISP write.
- R8: The fifth busy cycle writes the request's level to the priority level. The sixth writes PC: for a normal request, from a bus read at vector base plus 4 times the interrupt number; for a fast request, from the fast vector input with no read.
- R9: Busy lasts exactly six cycles per entry, with the steps in the order given in R4 to R8.
- R10: A request held high during an entry is not taken before busy has been low for at least one cycle. That cycle is where the handler's first instruction begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Interrupt request pending |
| req_level | input | 3 | Priority of the pending request |
| req_fast | input | 1 | Request is the fast (shadow) interrupt |
| insn_done | input | 1 | Current instruction completes this cycle |
| insn_abortable | input | 1 | Current instruction may be suspended |
| abandon | output | 1 | Core must suspend the current instruction |
| busy | output | 1 | Entry sequence in progress |
| cur_flg | input | 8 | Current flag register |
| cur_pc | input | 24 | Return address |
| cur_isp | input | 24 | Current interrupt stack pointer |
| intb | input | 24 | Vector table base |
| fast_vec | input | 24 | Fast interrupt vector register |
| bus_rd | output | 1 | Memory read strobe |
| bus_wr | output | 1 | Memory write strobe |
| bus_addr | output | 24 | Memory address |
| bus_wdata | output | 32 | Memory write data |
| bus_rdata | input | 32 | Memory read data, same cycle |
| ack_clr | output | 1 | Clear request bit of source ack_num |
| ack_num | output | 8 | Interrupt number being acknowledged |
| flg_we | output | 1 | Flag register write |
| flg_wdata | output | 8 | New flag value |
| isp_we | output | 1 | Stack pointer write |
| isp_wdata | output | 24 | New stack pointer |
| svf_we | output | 1 | Flag shadow write |
| svf_wdata | output | 8 | Flag shadow value |
| svp_we | output | 1 | PC shadow write |
| svp_wdata | output | 24 | PC shadow value |
| ipl_we | output | 1 | Priority level write |
| ipl_wdata | output | 3 | New priority level |
| pc_we | output | 1 | PC write |
| pc_wdata | output | 24 | Handler address |

## Verification
The assertions assume that insn_done and insn_abortable change only between clock edges. They also assume bus_rdata answers in the same cycle as bus_rd, and that the core keeps cur_flg steady while busy is high. The bench drives every input just after a rising edge from a task. It models memory as a pure function of bus_addr and holds core state constant through each entry. It samples outputs on the falling edge, so every strobe is seen in the cycle that R4 to R9 name.

// File: rtl/irq_entry_pkg.sv
// Shared types and flag bit positions for the interrupt entry sequencer.
package irq_entry_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ACK, ST_FLAGS, ST_SAVEF, ST_SAVEPC, ST_IPL, ST_VEC
    } ent_state_t;

    localparam int FLG_STEP_BIT   = 4;
    localparam int FLG_IE_BIT     = 6;
    localparam int FLG_STKSEL_BIT = 7;
endpackage

// File: rtl/irq_entry_fsm.sv
// Step controller: decides acceptance at an instruction boundary (or on a
// suspendable instruction) and walks the fixed entry steps one per cycle.
// Assumes insn_done/insn_abortable are stable around the clock edge.
module irq_entry_fsm
    import irq_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       insn_done,
    input  logic       insn_abortable,
    output ent_state_t state,
    output logic       accept,
    output logic       abandon
);
    ent_state_t state_nx;

    // Acceptance only while idle and at a point where the core can stop.
    always_comb begin
        accept  = (state == ST_IDLE) && req_valid && (insn_done || insn_abortable);
        abandon = accept && insn_abortable && !insn_done;
    end

    // Fixed step order; every step lasts one cycle.
    always_comb begin
        case (state)
            ST_IDLE:   state_nx = accept ? ST_ACK : ST_IDLE;
            ST_ACK:    state_nx = ST_FLAGS;
            ST_FLAGS:  state_nx = ST_SAVEF;
            ST_SAVEF:  state_nx = ST_SAVEPC;
            ST_SAVEPC: state_nx = ST_IPL;
            ST_IPL:    state_nx = ST_VEC;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R3: abandon never asserted while the sequence is already running.
    assert_abandon_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        abandon |-> (state == ST_IDLE) && !insn_done);

    // R9: once the vector step is reached, the sequence returns to idle.
    assert_vec_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VEC) |=> (state == ST_IDLE));
endmodule

// File: rtl/irq_entry_dp.sv
// Datapath: latches the request context, drives the memory bus and the
// register write strobes for each step. Assumes a zero-wait bus whose read
// data is valid in the cycle of bus_rd, and DW >= AW.
module irq_entry_dp
    import irq_entry_pkg::*;
#(
    parameter int AW         = 24,
    parameter int DW         = 32,
    parameter int FW         = 8,
    parameter int LW         = 3,
    parameter int NW         = 8,
    parameter int FLAG_BYTES = 2,
    parameter int PC_BYTES   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ent_state_t    state,
    input  logic          accept,
    input  logic [LW-1:0] req_level,
    input  logic          req_fast,
    input  logic [FW-1:0] cur_flg,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] cur_isp,
    input  logic [AW-1:0] intb,
    input  logic [AW-1:0] fast_vec,
    input  logic [DW-1:0] bus_rdata,
    output logic          fast_q,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          ack_clr,
    output logic [NW-1:0] ack_num,
    output logic          flg_we,
    output logic [FW-1:0] flg_wdata,
    output logic          isp_we,
    output logic [AW-1:0] isp_wdata,
    output logic          svf_we,
    output logic [FW-1:0] svf_wdata,
    output logic          svp_we,
    output logic [AW-1:0] svp_wdata,
    output logic          ipl_we,
    output logic [LW-1:0] ipl_wdata,
    output logic          pc_we,
    output logic [AW-1:0] pc_wdata
);
    localparam logic [AW-1:0] ACK_ADDR_NORM = '0;
    localparam logic [AW-1:0] ACK_ADDR_FAST = AW'(2);
    localparam logic [AW-1:0] FLAG_STEP     = AW'(FLAG_BYTES);
    localparam logic [AW-1:0] PC_STEP       = AW'(PC_BYTES);
    localparam logic [FW-1:0] CLR_MASK      = FW'((1 << FLG_STEP_BIT) |
                                                  (1 << FLG_IE_BIT) |
                                                  (1 << FLG_STKSEL_BIT));

    logic [LW-1:0] level_q;
    logic [AW-1:0] ret_pc_q;
    logic [AW-1:0] sp_q;
    logic [NW-1:0] num_q;
    logic [FW-1:0] tmp_flg_q;
    logic [AW-1:0] sp_flag_slot;
    logic [AW-1:0] sp_pc_slot;
    logic [AW-1:0] vec_addr;

    assign sp_flag_slot = sp_q - FLAG_STEP;
    assign sp_pc_slot   = sp_q - PC_STEP;
    assign vec_addr     = intb + (AW'(num_q) << 2);

    // Capture request context, interrupt number, temp flags and stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q   <= '0;
            fast_q    <= 1'b0;
            ret_pc_q  <= '0;
            sp_q      <= '0;
            num_q     <= '0;
            tmp_flg_q <= '0;
        end else begin
            if (accept) begin
                level_q  <= req_level;
                fast_q   <= req_fast;
                ret_pc_q <= cur_pc;
                sp_q     <= cur_isp;
            end
            if (state == ST_ACK) begin
                num_q     <= bus_rdata[NW-1:0];
                tmp_flg_q <= cur_flg;
            end
            if (!fast_q && state == ST_SAVEF)  sp_q <= sp_flag_slot;
            if (!fast_q && state == ST_SAVEPC) sp_q <= sp_pc_slot;
        end
    end

    // Per-step bus and register strobes.
    always_comb begin
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        ack_clr   = 1'b0;
        ack_num   = num_q;
        flg_we    = 1'b0;
        flg_wdata = tmp_flg_q & ~CLR_MASK;
        isp_we    = 1'b0;
        isp_wdata = '0;
        svf_we    = 1'b0;
        svf_wdata = tmp_flg_q;
        svp_we    = 1'b0;
        svp_wdata = ret_pc_q;
        ipl_we    = 1'b0;
        ipl_wdata = level_q;
        pc_we     = 1'b0;
        pc_wdata  = fast_q ? fast_vec : bus_rdata[AW-1:0];
        case (state)
            ST_ACK: begin
                bus_rd   = 1'b1;
                bus_addr = fast_q ? ACK_ADDR_FAST : ACK_ADDR_NORM;
            end
            ST_FLAGS: begin
                flg_we  = 1'b1;
                ack_clr = 1'b1;
            end
            ST_SAVEF: begin
                if (fast_q) begin
                    svf_we = 1'b1;
                end else begin
                    bus_wr    = 1'b1;
                    bus_addr  = sp_flag_slot;
                    bus_wdata = DW'(tmp_flg_q);
                    isp_we    = 1'b1;
                    isp_wdata = sp_flag_slot;
                end
            end
            ST_SAVEPC: begin
                if (fast_q) begin
                    svp_we = 1'b1;
                end else begin
                    bus_wr    = 1'b1;
                    bus_addr  = sp_pc_slot;
                    bus_wdata = DW'(ret_pc_q);
                    isp_we    = 1'b1;
                    isp_wdata = sp_pc_slot;
                end
            end
            ST_IPL: ipl_we = 1'b1;
            ST_VEC: begin
                pc_we = 1'b1;
                if (!fast_q) begin
                    bus_rd   = 1'b1;
                    bus_addr = vec_addr;
                end
            end
            default: ;
        endcase
    end

    // R6: each stack write lands exactly where the new stack pointer points.
    assert_push_at_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && isp_we) |-> (bus_addr == isp_wdata));

    // R6: the PC is written PC_BYTES below the flag word written just before.
    assert_pc_below_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && $past(bus_wr)) |-> (bus_addr == $past(bus_addr) - PC_STEP));

    // R7: shadow saves never coincide with stack traffic.
    assert_fast_no_stack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (svf_we || svp_we) |-> (!bus_wr && !isp_we));
endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry sequencer top: joins the step controller and the datapath.
// Assumes the core stalls and holds cur_flg, cur_pc and cur_isp while busy.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int AW         = 24,
    parameter int DW         = 32,
    parameter int FW         = 8,
    parameter int LW         = 3,
    parameter int NW         = 8,
    parameter int FLAG_BYTES = 2,
    parameter int PC_BYTES   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [LW-1:0] req_level,
    input  logic          req_fast,
    input  logic          insn_done,
    input  logic          insn_abortable,
    output logic          abandon,
    output logic          busy,
    input  logic [FW-1:0] cur_flg,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] cur_isp,
    input  logic [AW-1:0] intb,
    input  logic [AW-1:0] fast_vec,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          ack_clr,
    output logic [NW-1:0] ack_num,
    output logic          flg_we,
    output logic [FW-1:0] flg_wdata,
    output logic          isp_we,
    output logic [AW-1:0] isp_wdata,
    output logic          svf_we,
    output logic [FW-1:0] svf_wdata,
    output logic          svp_we,
    output logic [AW-1:0] svp_wdata,
    output logic          ipl_we,
    output logic [LW-1:0] ipl_wdata,
    output logic          pc_we,
    output logic [AW-1:0] pc_wdata
);
    ent_state_t state;
    logic       accept;
    logic       fast_q;

    assign busy = (state != ST_IDLE);

    irq_entry_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .insn_done      (insn_done),
        .insn_abortable (insn_abortable),
        .state          (state),
        .accept         (accept),
        .abandon        (abandon)
    );

    irq_entry_dp #(
        .AW(AW), .DW(DW), .FW(FW), .LW(LW), .NW(NW),
        .FLAG_BYTES(FLAG_BYTES), .PC_BYTES(PC_BYTES)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .req_level (req_level),
        .req_fast  (req_fast),
        .cur_flg   (cur_flg),
        .cur_pc    (cur_pc),
        .cur_isp   (cur_isp),
        .intb      (intb),
        .fast_vec  (fast_vec),
        .bus_rdata (bus_rdata),
        .fast_q    (fast_q),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ack_clr   (ack_clr),
        .ack_num   (ack_num),
        .flg_we    (flg_we),
        .flg_wdata (flg_wdata),
        .isp_we    (isp_we),
        .isp_wdata (isp_wdata),
        .svf_we    (svf_we),
        .svf_wdata (svf_wdata),
        .svp_we    (svp_we),
        .svp_wdata (svp_wdata),
        .ipl_we    (ipl_we),
        .ipl_wdata (ipl_wdata),
        .pc_we     (pc_we),
        .pc_wdata  (pc_wdata)
    );

    // R2: a sequence starts only after a boundary or a suspendable instruction.
    assert_start_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && (insn_done || insn_abortable)));

    // R5: the written flag word always has the three control bits cleared.
    assert_flags_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flg_we |-> (!flg_wdata[FLG_IE_BIT] && !flg_wdata[FLG_STEP_BIT] &&
                    !flg_wdata[FLG_STKSEL_BIT]));

    // R8: the handler PC is loaded only right after the level update.
    assert_pc_after_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> $past(ipl_we));

    // R4: the request clear follows the acknowledge read by one cycle.
    assert_clear_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_clr |-> ($past(bus_rd) && $past(busy) && busy));

    // R7: a fast entry never touches the memory bus for writes.
    assert_fast_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fast_q) |-> !bus_wr);
endmodule

// File: tb/irq_entry_seq_bench.sv
// Directed bench for the interrupt entry sequencer; one task per scenario.
module irq_entry_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_level = '0;
    logic        req_fast = 1'b0;
    logic        insn_done = 1'b0;
    logic        insn_abortable = 1'b0;
    logic        abandon, busy;
    logic [7:0]  cur_flg = '0;
    logic [23:0] cur_pc = '0, cur_isp = '0, intb = '0, fast_vec = '0;
    logic        bus_rd, bus_wr;
    logic [23:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        ack_clr;
    logic [7:0]  ack_num;
    logic        flg_we, isp_we, svf_we, svp_we, ipl_we, pc_we;
    logic [7:0]  flg_wdata, svf_wdata;
    logic [23:0] isp_wdata, svp_wdata, pc_wdata;
    logic [2:0]  ipl_wdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: number at 0 / 2, otherwise a function of the address.
    always_comb begin
        if (bus_addr == 24'h0)      bus_rdata = 32'h0000_002A;
        else if (bus_addr == 24'h2) bus_rdata = 32'h0000_0005;
        else                        bus_rdata = {8'h00, bus_addr ^ 24'hF00000};
    end

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .req_fast(req_fast), .insn_done(insn_done), .insn_abortable(insn_abortable),
        .abandon(abandon), .busy(busy), .cur_flg(cur_flg), .cur_pc(cur_pc),
        .cur_isp(cur_isp), .intb(intb), .fast_vec(fast_vec), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ack_clr(ack_clr), .ack_num(ack_num),
        .flg_we(flg_we), .flg_wdata(flg_wdata), .isp_we(isp_we),
        .isp_wdata(isp_wdata), .svf_we(svf_we), .svf_wdata(svf_wdata),
        .svp_we(svp_we), .svp_wdata(svp_wdata), .ipl_we(ipl_we),
        .ipl_wdata(ipl_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata)
    );

    // Event log, sampled on the falling edge.
    int          cyc = 0;
    int          rd_n, wr_n, isp_n, busy_cnt;
    logic [23:0] rd_addr [4];
    int          rd_cyc  [4];
    logic [23:0] wr_addr [4];
    logic [31:0] wr_data [4];
    int          wr_cyc  [4];
    logic [23:0] isp_last;
    int          flg_cyc, clr_cyc, svf_cyc, svp_cyc, ipl_cyc, pc_cyc;
    logic [7:0]  flg_val, clr_num, svf_val;
    logic [23:0] svp_val, pc_val;
    logic [2:0]  ipl_val;
    bit          abandon_seen;

    task automatic clear_log();
        rd_n = 0; wr_n = 0; isp_n = 0; busy_cnt = 0; abandon_seen = 0;
        flg_cyc = -1; clr_cyc = -1; svf_cyc = -1; svp_cyc = -1;
        ipl_cyc = -1; pc_cyc = -1;
        flg_val = '0; clr_num = '0; svf_val = '0; svp_val = '0; pc_val = '0;
        ipl_val = '0; isp_last = '0;
    endtask

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (busy) busy_cnt = busy_cnt + 1;
        if (abandon) abandon_seen = 1;
        if (bus_rd && rd_n < 4) begin
            rd_addr[rd_n] = bus_addr; rd_cyc[rd_n] = cyc; rd_n = rd_n + 1;
        end
        if (bus_wr && wr_n < 4) begin
            wr_addr[wr_n] = bus_addr; wr_data[wr_n] = bus_wdata;
            wr_cyc[wr_n] = cyc; wr_n = wr_n + 1;
        end
        if (isp_we) begin isp_n = isp_n + 1; isp_last = isp_wdata; end
        if (flg_we) begin flg_cyc = cyc; flg_val = flg_wdata; end
        if (ack_clr) begin clr_cyc = cyc; clr_num = ack_num; end
        if (svf_we) begin svf_cyc = cyc; svf_val = svf_wdata; end
        if (svp_we) begin svp_cyc = cyc; svp_val = svp_wdata; end
        if (ipl_we) begin ipl_cyc = cyc; ipl_val = ipl_wdata; end
        if (pc_we) begin pc_cyc = cyc; pc_val = pc_wdata; end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present a request for one cycle with the given qualifiers.
    task automatic pulse_request(input bit fast, input logic [2:0] lvl,
                                 input bit done, input bit abortable);
        @(posedge clk); #1;
        req_valid = 1; req_fast = fast; req_level = lvl;
        insn_done = done; insn_abortable = abortable;
        @(posedge clk); #1;
        req_valid = 0; insn_done = 0; insn_abortable = 0;
        repeat (10) @(posedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check_eq("R1 busy after reset", busy, 0);
        check_eq("R1 strobes after reset",
                 {abandon, bus_rd, bus_wr, ack_clr, flg_we, isp_we,
                  svf_we, svp_we, ipl_we, pc_we}, 0);
    endtask

    task automatic test_normal_entry();
        int c;
        cur_flg = 8'hFF; cur_pc = 24'h123456; cur_isp = 24'h008000;
        intb = 24'h0F0000; fast_vec = 24'h055550;
        clear_log();
        pulse_request(0, 3'd5, 1, 0);
        c = rd_cyc[0];
        check_eq("R4 ack address normal", rd_addr[0], 24'h000000);
        check_eq("R4 clear number", clr_num, 8'h2A);
        check_eq("R4 clear one cycle after read", clr_cyc, c + 1);
        check_eq("R5 flags cleared, others kept", flg_val, 8'h2F);
        check_eq("R6 two stack writes", wr_n, 2);
        check_eq("R6 flag push address", wr_addr[0], 24'h007FFE);
        check_eq("R6 flag push data", wr_data[0], 32'h0000_00FF);
        check_eq("R6 pc push address", wr_addr[1], 24'h007FFA);
        check_eq("R6 pc push data", wr_data[1], 32'h0012_3456);
        check_eq("R6 final isp", isp_last, 24'h007FFA);
        check_eq("R8 level written", ipl_val, 3'd5);
        check_eq("R8 vector read address", rd_addr[1], 24'h0F00A8);
        check_eq("R8 handler pc", pc_val, 24'hFF00A8);
        check_eq("R9 busy length", busy_cnt, 6);
        check_eq("R9 order flags", flg_cyc, c + 1);
        check_eq("R9 order flag push", wr_cyc[0], c + 2);
        check_eq("R9 order pc push", wr_cyc[1], c + 3);
        check_eq("R9 order level", ipl_cyc, c + 4);
        check_eq("R9 order pc load", pc_cyc, c + 5);
        check_eq("R2 no abandon on completed insn", abandon_seen, 0);
    endtask

    task automatic test_fast_entry();
        int c;
        cur_flg = 8'h43; cur_pc = 24'h00ABCD; cur_isp = 24'h004000;
        clear_log();
        pulse_request(1, 3'd7, 1, 0);
        c = rd_cyc[0];
        check_eq("R4 ack address fast", rd_addr[0], 24'h000002);
        check_eq("R8 fast has no vector read", rd_n, 1);
        check_eq("R4 fast clear number", clr_num, 8'h05);
        check_eq("R5 fast flags", flg_val, 8'h03);
        check_eq("R7 flag shadow", svf_val, 8'h43);
        check_eq("R7 pc shadow", svp_val, 24'h00ABCD);
        check_eq("R7 no bus writes", wr_n, 0);
        check_eq("R7 no isp write", isp_n, 0);
        check_eq("R7 shadow order", {svf_cyc == c + 2, svp_cyc == c + 3}, 2'b11);
        check_eq("R8 fast level", ipl_val, 3'd7);
        check_eq("R8 fast handler pc", pc_val, 24'h055550);
        check_eq("R9 fast busy length", busy_cnt, 6);
    endtask

    task automatic test_wait_for_boundary();
        cur_flg = 8'h00; cur_pc = 24'h000100; cur_isp = 24'h002000;
        clear_log();
        @(posedge clk); #1;
        req_valid = 1; req_fast = 0; req_level = 3'd2;
        repeat (5) @(posedge clk);
        #1;
        check_eq("R2 held off mid-instruction", busy_cnt, 0);
        insn_done = 1;
        @(posedge clk); #1;
        req_valid = 0; insn_done = 0;
        @(negedge clk);
        check_eq("R2 busy after boundary", busy, 1);
        repeat (10) @(posedge clk);
        check_eq("R2 entry completed", busy_cnt, 6);
    endtask

    task automatic test_abort_string();
        cur_pc = 24'h000200; cur_isp = 24'h003000;
        clear_log();
        pulse_request(0, 3'd1, 0, 1);
        check_eq("R3 abandon pulse", abandon_seen, 1);
        check_eq("R3 entry without completion", busy_cnt, 6);
        check_eq("R3 suspended pc pushed", wr_data[1], 32'h0000_0200);
    endtask

    task automatic test_held_request();
        bit hist [14];
        cur_isp = 24'h006000;
        @(posedge clk); #1;
        req_valid = 1; req_fast = 0; req_level = 3'd4; insn_done = 1;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            hist[i] = busy;
        end
        @(posedge clk); #1;
        req_valid = 0; insn_done = 0;
        check_eq("R10 first entry runs six cycles",
                 {hist[1], hist[2], hist[3], hist[4], hist[5], hist[6]}, 6'h3F);
        check_eq("R10 idle gap before next entry", hist[7], 0);
        check_eq("R10 next entry after gap", hist[8], 1);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check_eq("R10 returns idle", busy, 0);
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clear_log();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        test_reset();
        test_normal_entry();
        test_fast_entry();
        test_wait_for_boundary();
        test_abort_string();
        test_held_request();
        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule